// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

An eight-pin general-purpose I/O port that a processor reaches through a small register bus. Three registers are visible. The direction register sets each pin to input or output. The latch register holds the value each output pin drives. The level register reads the synchronized levels on the pins. A write to the level register goes to the output latch and never to the pins themselves. Because the latch register can be read back, a read-modify-write sequence works on the driven value and not on the pin level.

Configuration inputs shape the read paths. An analog mask makes selected pins read as zero in the level register. These pins still drive their outputs when their direction bit is clear. A second input hands the two top pins to the oscillator. When it is set, those pins read as zero in all three registers and their output drivers are switched off. A fault-detect output follows the synchronized level of pin 5 or pin 7. A single select input picks which one.

Pin inputs pass through a two-flop synchronizer. Each read is captured into a read-data register one cycle after the read strobe. That register then holds its value until the next read.

Top module: `pin_port`

## Requirements
- R1: Direction bit 1 makes the pin an input, so `padOutEn` for that pin is 0. Direction bit 0 sets `padOutEn` to 1, and `padOut` carries the latch bit for that pin.
- R2: A write to address 0 (level register) updates the output latch. The next latch read returns the written value.
- R3: A read of address 1 (latch register) returns the latched value whatever the pin levels are.
- R4: A read of address 0 returns the pin levels as seen after a two-flop synchronizer. A pin change made before clock edge e becomes visible to a read strobe sampled at edge e+2.
- R5: When bit i of `analogMask` is 1, bit i of a level read is 0. The latch bit, the direction bit and the driving of that pin do not change.
- R6: While `oscOwnsTop` is 1, bits 7 and 6 read as 0 at addresses 0, 1 and 2, and `padOutEn[7:6]` and `padOut[7:6]` are 0.
- R7: `faultIn` is the synchronized level of pin 5 when `faultSelHigh` is 0, and of pin 7 when it is 1. It is 0 when pin 7 is selected while the oscillator owns it.
- R8: After reset the direction register reads 0xFF, the latch reads 0x00, `busRdData` is 0x00, and no pin is driven.
- R9: `busRdData` is updated only on the cycle after a read strobe and holds otherwise. A read and a write to the same register in the same cycle return the value from before the write.
- R10: Address 3 is unused. Writes to it change nothing, and reads of it return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 2 | Register select: 0 level, 1 latch, 2 direction |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, valid the cycle after a read strobe |
| padIn | input | 8 | Pin input levels (asynchronous) |
| padOutEn | output | 8 | Per-pin output-driver enable, 1 = drive |
| padOut | output | 8 | Per-pin output value |
| analogMask | input | 8 | 1 = pin is analog and reads as 0 in the level register |
| oscOwnsTop | input | 1 | 1 = pins 7 and 6 belong to the oscillator |
| faultSelHigh | input | 1 | Fault source: 0 pin 5, 1 pin 7 |
| faultIn | output | 1 | Synchronized fault-detect level |

## Verification
Two events can fall on the same clock edge: a read strobe and a write strobe to the same latch register. The bench drives both in one cycle and checks that the returned data is the value from before the write. A second read then checks that the new value was stored. The same kind of overlap is provoked on the input side. Back-to-back level reads are issued right after a pin change, and the scoreboard expects the old level for two reads and the new level on the third. This pins down the synchronizer latency against the read-capture register.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_LEVEL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LATCH = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DIR   = 2'd2;

  typedef struct packed {
    logic wrLatch;
    logic wrDir;
    logic rdAny;
    logic rdLevel;
    logic rdLatch;
    logic rdDir;
  } port_strobe_t;
endpackage

// File: rtl/pin_port_ctrl.sv
module pin_port_ctrl
  import pin_port_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output port_strobe_t      strobes
);
  always_comb begin
    strobes = '0;
    // writes to level or latch address both land in the output latch
    strobes.wrLatch = busWrEn && (busAddr == ADDR_LEVEL || busAddr == ADDR_LATCH);
    strobes.wrDir   = busWrEn && (busAddr == ADDR_DIR);
    strobes.rdAny   = busRdEn;
    strobes.rdLevel = busRdEn && (busAddr == ADDR_LEVEL);
    strobes.rdLatch = busRdEn && (busAddr == ADDR_LATCH);
    strobes.rdDir   = busRdEn && (busAddr == ADDR_DIR);
  end
endmodule

// File: rtl/pin_port_datapath.sv
module pin_port_datapath
  import pin_port_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int OSC_PINS    = 2,
  parameter int FAULT_LO    = 5,
  parameter int FAULT_HI    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  port_strobe_t      strobes,
  input  logic [PORT_W-1:0] wrData,
  input  logic [PORT_W-1:0] padIn,
  input  logic [PORT_W-1:0] analogMask,
  input  logic              oscOwnsTop,
  input  logic              faultSelHigh,
  output logic [PORT_W-1:0] rdData,
  output logic [PORT_W-1:0] padOutEn,
  output logic [PORT_W-1:0] padOut,
  output logic              faultIn
);
  localparam logic [PORT_W-1:0] OSC_MASK =
    {{OSC_PINS{1'b1}}, {(PORT_W-OSC_PINS){1'b0}}};

  logic [PORT_W-1:0] latchQ, dirQ;
  logic [PORT_W-1:0] syncQ [SYNC_STAGES];
  logic [PORT_W-1:0] oscKeep, latchEff, dirEff, levelEff, pinSync;

  // input synchronizer chain
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= padIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate
  assign pinSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
      dirQ   <= '1;
    end else begin
      if (strobes.wrLatch) latchQ <= wrData;
      if (strobes.wrDir)   dirQ   <= wrData;
    end
  end

  assign oscKeep  = oscOwnsTop ? ~OSC_MASK : '1;
  assign latchEff = latchQ & oscKeep;
  assign dirEff   = dirQ & oscKeep;
  assign levelEff = pinSync & ~analogMask & oscKeep;

  assign padOutEn = ~dirQ & oscKeep;
  assign padOut   = latchEff;

  always_comb begin
    if (faultSelHigh) faultIn = pinSync[FAULT_HI] & ~(oscOwnsTop && FAULT_HI >= PORT_W-OSC_PINS);
    else              faultIn = pinSync[FAULT_LO];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strobes.rdAny) begin
      unique case (1'b1)
        strobes.rdLevel: rdData <= levelEff;
        strobes.rdLatch: rdData <= latchEff;
        strobes.rdDir:   rdData <= dirEff;
        default:         rdData <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pin_port.sv
module pin_port
  import pin_port_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busAddr,
  input  logic       busWrEn,
  input  logic       busRdEn,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  input  logic [7:0] padIn,
  output logic [7:0] padOutEn,
  output logic [7:0] padOut,
  input  logic [7:0] analogMask,
  input  logic       oscOwnsTop,
  input  logic       faultSelHigh,
  output logic       faultIn
);
  port_strobe_t strobes;

  pin_port_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobes (strobes)
  );

  pin_port_datapath #(
    .PORT_W(8), .OSC_PINS(2), .FAULT_LO(5), .FAULT_HI(7), .SYNC_STAGES(2)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .wrData       (busWrData),
    .padIn        (padIn),
    .analogMask   (analogMask),
    .oscOwnsTop   (oscOwnsTop),
    .faultSelHigh (faultSelHigh),
    .rdData       (busRdData),
    .padOutEn     (padOutEn),
    .padOut       (padOut),
    .faultIn      (faultIn)
  );
endmodule

// File: rtl/pin_port_checker.sv
module pin_port_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] busAddr,
  input logic       busWrEn,
  input logic       busRdEn,
  input logic [7:0] busWrData,
  input logic [7:0] busRdData,
  input logic [7:0] padOutEn,
  input logic [7:0] padOut,
  input logic [7:0] analogMask,
  input logic       oscOwnsTop
);
  assert_dir_drive_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd2 && !oscOwnsTop) |=> (padOutEn[5:0] == ~$past(busWrData[5:0])));

  assert_level_wr_latch_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd0) |=> (padOut[5:0] == $past(busWrData[5:0])));

  assert_analog_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == 2'd0) |=> ((busRdData & $past(analogMask)) == 8'h00));

  assert_osc_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    oscOwnsTop |-> (padOutEn[7:6] == 2'b00 && padOut[7:6] == 2'b00));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> $stable(busRdData));

  assert_unused_addr_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == 2'd3) |=> (busRdData == 8'h00));
endmodule

bind pin_port pin_port_checker u_chk (.*);

// File: tb/pin_port_bench.sv
module pin_port_bench;
  logic       clk = 0;
  logic       rstN = 0;
  logic [1:0] busAddr = 0;
  logic       busWrEn = 0, busRdEn = 0;
  logic [7:0] busWrData = 0;
  logic [7:0] busRdData;
  logic [7:0] padIn = 0;
  logic [7:0] padOutEn, padOut;
  logic [7:0] analogMask = 8'h33;
  logic       oscOwnsTop = 0, faultSelHigh = 0;
  logic       faultIn;

  int vectors = 0, miscompares = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       rdSeen = 0;

  always #10 clk = ~clk;

  pin_port u_pin_port (.*);

  // monitor: a read strobed at a posedge is compared at the following negedge
  always @(posedge clk) rdSeen <= busRdEn;
  always @(negedge clk) begin
    if (rdSeen && rstN) begin
      if (expQ.size() == 0) begin
        miscompares++;
        $display("FAIL scoreboard: read data 0x%02h with no expected item", busRdData);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        vectors++;
        if (busRdData !== e) begin
          miscompares++;
          $display("FAIL %s: busRdData actual 0x%02h expected 0x%02h", t, busRdData, e);
        end
      end
    end
  end

  task automatic checkVal(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeReg(logic [1:0] a, logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1;
    @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic readReg(logic [1:0] a, logic [7:0] exp, string tag);
    busAddr = a; busRdEn = 1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    busRdEn = 0;
  endtask

  initial begin
    idle(2);
    rstN = 1;
    @(negedge clk);
    // R8: reset state
    checkVal("R8 padOutEn", padOutEn, 8'h00);
    checkVal("R8 busRdData", busRdData, 8'h00);
    readReg(2'd2, 8'hFF, "R8 dir");
    readReg(2'd1, 8'h00, "R8 latch");

    // R1 and R5: drive, analog pins 4/5 still drive
    writeReg(2'd1, 8'hA5);
    writeReg(2'd2, 8'h0F);
    checkVal("R1 padOutEn", padOutEn, 8'hF0);
    checkVal("R1 padOut", padOut, 8'hA5);

    // R2: level address writes the latch
    writeReg(2'd0, 8'h3C);
    readReg(2'd1, 8'h3C, "R2 latch via level write");

    // R4, R5, R3
    padIn = 8'hFF;
    idle(3);
    readReg(2'd0, 8'hCC, "R5 level analog masked");
    readReg(2'd1, 8'h3C, "R3 latch independent of pins");
    readReg(2'd2, 8'h0F, "R5 dir untouched by mask");

    // R4 synchronizer latency with back-to-back reads
    padIn = 8'h00;
    busAddr = 2'd0; busRdEn = 1;
    expQ.push_back(8'hCC); tagQ.push_back("R4 edge+0 old level");
    expQ.push_back(8'hCC); tagQ.push_back("R4 edge+1 old level");
    expQ.push_back(8'h00); tagQ.push_back("R4 edge+2 new level");
    idle(3);
    busRdEn = 0;

    // R9: read and write same register in the same cycle
    busAddr = 2'd1; busWrData = 8'h11; busWrEn = 1; busRdEn = 1;
    expQ.push_back(8'h3C); tagQ.push_back("R9 read sees pre-write value");
    @(negedge clk);
    busWrEn = 0; busRdEn = 0;
    readReg(2'd1, 8'h11, "R9 write landed");
    idle(3);
    checkVal("R9 hold", busRdData, 8'h11);

    // R10: unused address
    writeReg(2'd3, 8'h77);
    readReg(2'd3, 8'h00, "R10 read unused");
    readReg(2'd1, 8'h11, "R10 latch unchanged");
    readReg(2'd2, 8'h0F, "R10 dir unchanged");

    // R7: fault source select
    padIn = 8'h20;
    idle(3);
    checkVal("R7 pin5 selected", {7'd0, faultIn}, 8'h01);
    faultSelHigh = 1;
    #1 checkVal("R7 pin7 low", {7'd0, faultIn}, 8'h00);
    padIn = 8'h80;
    idle(3);
    checkVal("R7 pin7 high", {7'd0, faultIn}, 8'h01);

    // R6: oscillator owns top pins
    oscOwnsTop = 1;
    #1 checkVal("R7 osc-owned pin7", {7'd0, faultIn}, 8'h00);
    writeReg(2'd2, 8'h00);
    writeReg(2'd1, 8'hFF);
    checkVal("R6 padOutEn", padOutEn, 8'h3F);
    checkVal("R6 padOut", padOut, 8'h3F);
    padIn = 8'hFF;
    idle(3);
    readReg(2'd0, 8'h0C, "R6 level top bits zero");
    readReg(2'd1, 8'h3F, "R6 latch top bits zero");
    readReg(2'd2, 8'h00, "R6 dir top bits zero");
    idle(2);
    checkVal("scoreboard drained", 8'(expQ.size()), 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule